// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block models a two-wire serial EEPROM slave. It holds a 1024 x 8 storage array, runs from a fast system clock, and oversamples the bus clock and data lines through short synchronisers. It pulls the data line low through an output-enable signal and never drives it high, so it can share an open-drain bus with other devices.

A bus master addresses the block with a device byte. That byte carries a fixed type nibble, one select bit that must match a strapped pin, the two upper memory-address bits and a read/write flag. The block supports four transfers:

- a byte write, which is committed at STOP and then opens a timed busy window;
- a current-address read;
- a random read, which is an address write followed by a repeated START;
- a sequential read, which advances through the array while the master acknowledges.

A write-protect pin freezes the whole array.

Top module: `serial_eeprom_slave`

## Requirements
- R1: An SDA fall while SCL is high is a START. From any state, including part-way through a byte, it makes the block expect a fresh device-address byte.
- R2: An SDA rise while SCL is high is a STOP. It returns the block to idle and releases SDA. A byte write is stored into the array only on this STOP.
- R3: Incoming bits are taken on SCL rising edges. The block changes its SDA drive only after an SCL falling edge, and never while SCL stays high.
- R4: After each 8-bit byte it accepts, the block pulls SDA low for the whole ninth SCL clock. `sda_oe_o` = 1 means pull low and 0 means release, and SDA is never driven high.
- R5: The device byte is sent MSB first. Bits 7..4 must be 1010 and bit 3 must equal `a2_sel_i`. On a mismatch the block gives no acknowledge and leaves SDA released until the next START.
- R6: Byte write sequence: device byte with bit 0 = 0 and bits 2..1 = address bits 9..8, then address bits 7..0, then one data byte, then STOP. The byte is stored at that 10-bit address, and the address pointer becomes that address plus one.
- R7: Random read: a write-type device byte and an address byte, then a repeated START and a device byte with bit 0 = 1. The block returns the stored byte at that address, MSB first.
- R8: Current-address read: a read device byte with no address phase returns the byte at the pointer. Bits 2..1 of that device byte replace pointer bits 9..8. After every byte sent, the pointer advances by one.
- R9: In a read, a master acknowledge (SDA low on the ninth clock) sends the byte at the next address, wrapping from 1023 to 0. A master not-acknowledge followed by STOP ends the read.
- R10: While `wp_i` is high, data bytes are still acknowledged, but the array is left unchanged and no busy window starts.
- R11: For `WCYCLE_CLKS` system clocks after a committed write, every device byte goes unacknowledged. After that window, device bytes are acknowledged again.
- R12: A repeated START between the data byte and STOP cancels the write. The array is left unchanged and no busy window starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired level) |
| a2_sel_i | input | 1 | Strapped select pin compared with device-byte bit 3 |
| wp_i | input | 1 | Write protect, high locks the array |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
The device byte is swept over all sixteen type nibbles and both select-bit values, with the select pin at each level. This separates the one accepted pattern from every near miss. Byte writes are made to addresses in all four upper-address pages, including 0 and 1023. Each is read back both by random read and by current-address read, which tells the explicit-address path apart from the pointer-increment path. A sequential read that starts just below 1023 shows the wrap to 0. Three further sequences each have their own signature in the acknowledges they draw and the data they read back: writes under protection, a write followed by an immediate device byte (busy), and a repeated START that cuts a write short.

// File: rtl/seep_pkg.sv
package seep_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_MACK
    } seep_state_e;

    typedef enum logic [1:0] {
        K_DEV,
        K_ADDR,
        K_DATA
    } seep_kind_e;

    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } seep_bus_ev_t;

    localparam logic [3:0] SEEP_DEV_TYPE = 4'b1010;

endpackage

// File: rtl/seep_line_sync.sv
module seep_line_sync
    import seep_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         scl_i,
    input  logic         sda_i,
    output logic         scl_lvl_o,
    output logic         sda_lvl_o,
    output seep_bus_ev_t ev_o
);

    localparam int LINES = 2;

    logic [LINES-1:0] raw;
    logic [LINES-1:0] pipe_q [STAGES];
    logic [LINES-1:0] prev_q;

    assign raw = {scl_i, sda_i};

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    pipe_q[g] <= '1;
                end else if (g == 0) begin
                    pipe_q[g] <= raw;
                end else begin
                    pipe_q[g] <= pipe_q[(g == 0) ? 0 : g - 1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '1;
        end else begin
            prev_q <= pipe_q[STAGES-1];
        end
    end

    logic scl_now, sda_now, scl_old, sda_old;
    assign {scl_now, sda_now} = pipe_q[STAGES-1];
    assign {scl_old, sda_old} = prev_q;

    always_comb begin
        ev_o.scl_rise = scl_now & ~scl_old;
        ev_o.scl_fall = ~scl_now & scl_old;
        ev_o.start    = scl_now & scl_old & sda_old & ~sda_now;
        ev_o.stop     = scl_now & scl_old & ~sda_old & sda_now;
    end

    assign scl_lvl_o = scl_now;
    assign sda_lvl_o = sda_now;

endmodule

// File: rtl/seep_array.sv
module seep_array #(
    parameter int AW = 10,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [AW-1:0] raddr_i,
    output logic [DW-1:0] rdata_o
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else if (we_i) begin
            mem_q[waddr_i] <= wdata_i;
        end
    end

    assign rdata_o = mem_q[raddr_i];

endmodule

// File: rtl/seep_wtimer.sv
module seep_wtimer #(
    parameter int CLKS = 250000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o
);

    localparam int CW = $clog2(CLKS + 1);
    localparam logic [CW-1:0] LOAD = CW'(CLKS);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start_i) begin
            cnt_d = LOAD;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign busy_o = (cnt_q != '0);

    AST_TIMER_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> busy_o); // R11
    AST_NO_RESTART_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> !busy_o); // R11

endmodule

// File: rtl/serial_eeprom_slave.sv
module serial_eeprom_slave
    import seep_pkg::*;
#(
    parameter int AW          = 10,
    parameter int DW          = 8,
    parameter int SYNC_STAGES = 2,
    parameter int WCYCLE_CLKS = 250000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    input  logic a2_sel_i,
    input  logic wp_i,
    output logic sda_oe_o
);

    localparam int PAGE_W = AW - DW;
    localparam int CNT_W  = $clog2(DW + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DW - 1);
    localparam logic [CNT_W-1:0] FULL     = CNT_W'(DW);
    localparam logic [AW-1:0]    TOP_ADDR = '1;

    typedef struct packed {
        seep_state_e      st;
        seep_kind_e       kind;
        logic [CNT_W-1:0] cnt;
        logic [DW-1:0]    sh;
        logic [DW-1:0]    tx;
        logic [AW-1:0]    addr;
        logic             rd;
        logic             oe;
        logic             mack;
        logic             pend;
        logic [DW-1:0]    pdata;
    } seep_regs_t;

    seep_regs_t   d, q;
    seep_bus_ev_t ev;
    logic         scl_lvl, sda_lvl;
    logic         busy, we;
    logic [AW-1:0] rd_addr;
    logic [DW-1:0] rdata;

    seep_line_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_lvl_o (scl_lvl),
        .sda_lvl_o (sda_lvl),
        .ev_o      (ev)
    );

    assign rd_addr = (q.st == ST_MACK) ? q.addr + 1'b1 : q.addr;

    seep_array #(.AW(AW), .DW(DW)) i_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (we),
        .waddr_i (q.addr),
        .wdata_i (q.pdata),
        .raddr_i (rd_addr),
        .rdata_o (rdata)
    );

    seep_wtimer #(.CLKS(WCYCLE_CLKS)) i_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (we),
        .busy_o  (busy)
    );

    always_comb begin
        d  = q;
        we = 1'b0;
        if (ev.stop) begin
            if (q.pend) begin
                we     = 1'b1;
                d.addr = q.addr + 1'b1;
            end
            d.st   = ST_IDLE;
            d.oe   = 1'b0;
            d.pend = 1'b0;
        end else if (ev.start) begin
            d.st   = ST_RX;
            d.kind = K_DEV;
            d.cnt  = '0;
            d.oe   = 1'b0;
            d.pend = 1'b0;
        end else begin
            unique case (q.st)
                ST_RX: begin
                    if (ev.scl_rise && q.cnt < FULL) begin
                        d.sh  = {q.sh[DW-2:0], sda_lvl};
                        d.cnt = q.cnt + 1'b1;
                    end else if (ev.scl_fall && q.cnt == FULL) begin
                        d.cnt = '0;
                        unique case (q.kind)
                            K_DEV: begin
                                if (q.sh[DW-1 -: 4] == SEEP_DEV_TYPE &&
                                    q.sh[PAGE_W+1] == a2_sel_i && !busy) begin
                                    d.addr[AW-1 -: PAGE_W] = q.sh[PAGE_W:1];
                                    d.rd = q.sh[0];
                                    d.oe = 1'b1;
                                    d.st = ST_ACK;
                                end else begin
                                    d.st = ST_IDLE;
                                end
                            end
                            K_ADDR: begin
                                d.addr[DW-1:0] = q.sh;
                                d.oe = 1'b1;
                                d.st = ST_ACK;
                            end
                            default: begin
                                if (!wp_i) begin
                                    d.pend  = 1'b1;
                                    d.pdata = q.sh;
                                end
                                d.oe = 1'b1;
                                d.st = ST_ACK;
                            end
                        endcase
                    end
                end
                ST_ACK: begin
                    if (ev.scl_fall) begin
                        d.oe  = 1'b0;
                        d.cnt = '0;
                        if (q.kind == K_DEV && q.rd) begin
                            d.st = ST_TX;
                            d.tx = rdata;
                            d.oe = ~rdata[DW-1];
                        end else if (q.kind == K_DEV) begin
                            d.st   = ST_RX;
                            d.kind = K_ADDR;
                        end else if (q.kind == K_ADDR) begin
                            d.st   = ST_RX;
                            d.kind = K_DATA;
                        end else begin
                            d.st = ST_IDLE;
                        end
                    end
                end
                ST_TX: begin
                    if (ev.scl_fall) begin
                        if (q.cnt == LAST_BIT) begin
                            d.oe  = 1'b0;
                            d.cnt = '0;
                            d.st  = ST_MACK;
                        end else begin
                            d.tx  = {q.tx[DW-2:0], 1'b0};
                            d.oe  = ~q.tx[DW-2];
                            d.cnt = q.cnt + 1'b1;
                        end
                    end
                end
                ST_MACK: begin
                    if (ev.scl_rise) begin
                        d.mack = ~sda_lvl;
                    end else if (ev.scl_fall) begin
                        d.addr = q.addr + 1'b1;
                        if (q.mack) begin
                            d.st = ST_TX;
                            d.tx = rdata;
                            d.oe = ~rdata[DW-1];
                        end else begin
                            d.st = ST_IDLE;
                        end
                    end
                end
                default: begin
                    d.oe = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, kind: K_DEV, default: '0};
        end else begin
            q <= d;
        end
    end

    assign sda_oe_o = q.oe;

    AST_DRIVE_MOVES_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (q.oe != $past(q.oe)) |-> $past(ev.scl_fall || ev.start || ev.stop)); // R3
    AST_IDLE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IDLE) |-> !q.oe); // R5
    AST_BIT_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= FULL); // R4
    AST_BUSY_NO_DEV_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_ACK && q.kind == K_DEV) |-> !busy); // R11
    AST_PROTECT_NO_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.pend) |-> $past(!wp_i)); // R10
    AST_READ_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(q.st == ST_MACK && ev.scl_fall) && $past(q.addr) == TOP_ADDR)
        |-> q.addr == '0); // R9
    AST_STOP_IDLES: assert property (@(posedge clk) disable iff (!rst_n)
        ev.stop |=> (q.st == ST_IDLE && !q.oe)); // R2

endmodule

// File: tb/test_serial_eeprom_slave.sv
module test_serial_eeprom_slave;

    localparam int CLK_PERIOD = 10;
    localparam int Q          = 6;
    localparam int WC         = 300;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic a2_pin = 1'b1;
    logic wp = 1'b0;
    logic sda_oe;
    logic sda_bus;

    int checks = 0;
    int errors = 0;
    int r3_bad = 0;
    logic [7:0] model [1024];

    assign sda_bus = sda_m & ~sda_oe;

    always #(CLK_PERIOD/2) clk = ~clk;

    serial_eeprom_slave #(.WCYCLE_CLKS(WC)) i_serial_eeprom_slave (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_m),
        .sda_i    (sda_bus),
        .a2_sel_i (a2_pin),
        .wp_i     (wp),
        .sda_oe_o (sda_oe)
    );

    // R3 monitor: drive must not move during an SCL high phase
    logic prev_oe = 1'b0;
    logic prev_scl = 1'b1;
    always @(negedge clk) begin
        if (rst_n && scl_m && prev_scl && sda_oe != prev_oe) r3_bad++;
        prev_oe  <= sda_oe;
        prev_scl <= scl_m;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq();
        scl_m = 1'b1; wq();
        sda_m = 1'b0; wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq();
        scl_m = 1'b1; wq();
        sda_m = 1'b1; wq();
    endtask

    task automatic bit_out(input logic b);
        sda_m = b; wq();
        scl_m = 1'b1; wq(); wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic bit_in(output logic b);
        sda_m = 1'b1; wq();
        scl_m = 1'b1; wq();
        b = sda_bus; wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic send_byte(input logic [7:0] v, output bit ack);
        logic a;
        for (int i = 7; i >= 0; i--) bit_out(v[i]);
        bit_in(a);
        ack = (a == 1'b0);
    endtask

    task automatic recv_byte(output logic [7:0] v, input bit mack);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            bit_in(b);
            v[i] = b;
        end
        bit_out(mack ? 1'b0 : 1'b1);
    endtask

    function automatic logic [7:0] dev(input logic [9:0] a, input logic rd);
        return {4'b1010, a2_pin, a[9:8], rd};
    endfunction

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 37 + 11) ^ (a >> 2));
    endfunction

    task automatic do_write(input logic [9:0] a, input logic [7:0] v);
        bit k0, k1, k2;
        bus_start();
        send_byte(dev(a, 1'b0), k0);
        send_byte(a[7:0], k1);
        send_byte(v, k2);
        bus_stop();
        chk(k0 && k1 && k2, "R6 write acks", {k0, k1, k2}, 7);
        if (!wp) model[a] = v;
    endtask

    task automatic rand_read(input logic [9:0] a, output logic [7:0] v);
        bit k0, k1, k2;
        bus_start();
        send_byte(dev(a, 1'b0), k0);
        send_byte(a[7:0], k1);
        bus_start();
        send_byte(dev(a, 1'b1), k2);
        recv_byte(v, 1'b0);
        bus_stop();
        chk(k0 && k1 && k2, "R7 read acks", {k0, k1, k2}, 7);
    endtask

    logic [9:0] addrs [16];
    logic [7:0] v;
    bit ack;

    initial begin
        for (int i = 0; i < 1024; i++) model[i] = 8'h00;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(sda_oe == 1'b0, "R2 reset release", sda_oe, 0);

        // R5: device byte sweep, select pin high then low
        for (int p = 1; p >= 0; p--) begin
            a2_pin = p[0];
            for (int hi = 0; hi < 16; hi++) begin
                for (int ab = 0; ab < 2; ab++) begin
                    bus_start();
                    send_byte({hi[3:0], ab[0], 3'b000}, ack);
                    bus_stop();
                    chk(ack == (hi == 10 && ab == p), "R5 device match", ack,
                        (hi == 10 && ab == p));
                end
            end
        end
        a2_pin = 1'b1;

        // R6: byte writes across all pages
        for (int k = 0; k < 12; k++) addrs[k] = 10'((k * 181 + 5) % 1024);
        addrs[12] = 10'd1022; addrs[13] = 10'd1023;
        addrs[14] = 10'd0;    addrs[15] = 10'd1;
        for (int k = 0; k < 16; k++) begin
            do_write(addrs[k], pat(addrs[k]));
            repeat (WC + 40) @(negedge clk);
        end

        // R11: busy window refuses then releases
        do_write(10'd700, pat(700));
        bus_start(); send_byte(dev(10'd700, 1'b0), ack); bus_stop();
        chk(!ack, "R11 busy nack", ack, 0);
        repeat (WC + 40) @(negedge clk);
        bus_start(); send_byte(dev(10'd700, 1'b0), ack); bus_stop();
        chk(ack, "R11 ack after window", ack, 1);

        // R7 random read, R8 current read at pointer
        for (int k = 0; k < 16; k++) begin
            logic [9:0] a, nx;
            a = addrs[k];
            rand_read(a, v);
            chk(v == model[a], "R7 random read data", v, model[a]);
            nx = {a[9:8], a[7:0] + 8'd1};
            bus_start();
            send_byte(dev(a, 1'b1), ack);
            recv_byte(v, 1'b0);
            bus_stop();
            chk(ack && v == model[nx], "R8 current read data", v, model[nx]);
        end

        // R9 sequential read with wrap
        begin
            bit k0, k1, k2;
            logic [9:0] a;
            a = 10'd1020;
            bus_start();
            send_byte(dev(a, 1'b0), k0);
            send_byte(a[7:0], k1);
            bus_start();
            send_byte(dev(a, 1'b1), k2);
            for (int i = 0; i < 8; i++) begin
                logic [9:0] e;
                e = 10'((1020 + i) % 1024);
                recv_byte(v, i != 7);
                chk(v == model[e], "R9 sequential data", v, model[e]);
            end
            bus_stop();
            chk(k0 && k1 && k2, "R9 acks", {k0, k1, k2}, 7);
        end

        // R10 write protect
        wp = 1'b1;
        do_write(10'd5, ~model[5]);
        bus_start(); send_byte(dev(10'd5, 1'b0), ack); bus_stop();
        chk(ack, "R10 no busy under protect", ack, 1);
        wp = 1'b0;
        rand_read(10'd5, v);
        chk(v == model[5], "R10 array unchanged", v, model[5]);

        // R12 repeated START cancels write
        begin
            bit k0, k1, k2;
            bus_start();
            send_byte(dev(10'd300, 1'b0), k0);
            send_byte(8'd44, k1);
            send_byte(~model[300], k2);
            bus_start();
            send_byte(dev(10'd300, 1'b0), ack);
            bus_stop();
            chk(ack, "R12 no busy after cancel", ack, 1);
            rand_read(10'd300, v);
            chk(v == model[300], "R12 array unchanged", v, model[300]);
        end

        // R1 START part-way through a byte
        bus_start();
        bit_out(1'b1); bit_out(1'b0); bit_out(1'b1);
        rand_read(10'd1023, v);
        chk(v == model[1023], "R1 restart mid byte", v, model[1023]);

        chk(r3_bad == 0, "R3 drive stable while SCL high", r3_bad, 0);
        chk(sda_oe == 1'b0, "R4 released at end", sda_oe, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule